// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block is a register-mapped real-time clock. It holds seconds, minutes, hours, day of month, month, year and weekday as packed BCD bytes. While its run bit is set, each pulse on the one-second tick input advances the time, and the carries follow real month lengths and leap years. Six alarm bytes are compared against the time on every counted tick. A status byte collects periodic event flags, the alarm flag and a power-up flag, and one interrupt output is built from these flags and an enable byte.

Software reaches the block through a byte-wide register port. Reads are combinational from `bus_addr`. A write is a single-cycle `bus_wr` strobe and is always taken on that clock edge. The port never stalls, so there is no back-pressure. The time bytes can be rewritten only while the clock is stopped. For a coherent multi-byte read, software first writes the snapshot request bit and then reads the latched copy.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time is 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00. Control, interrupt-enable and alarm bytes are 0x00, status reads 0x80 (power-up flag only) and `irq` is low.
- R2: While control bit 0 is 1, each `sec_tick` pulse advances seconds in BCD. 0x59 wraps to 0x00 and carries into minutes, minutes wrap the same way into hours, and hours wrap 0x23 to 0x00.
- R3: An hour wrap advances the day and the weekday. The day wraps to 0x01 after 0x31, 0x30 (months 0x04, 0x06, 0x09, 0x11), 0x28 for February, or 0x29 for February when the year is divisible by 4. The month wraps 0x12 to 0x01 and carries into the year, the year wraps 0x99 to 0x00, and the weekday counts 0 to 6.
- R4: While control bit 0 is 0, ticks leave the time unchanged, and a write to offsets 0x00 to 0x06 (sec, min, hour, day, month, year, weekday) loads that byte directly. While control bit 0 is 1, such writes are ignored.
- R5: Status bit 1 shows the value control bit 0 had at the most recent tick.
- R6: Writing control (offset 0x0D) with bit 6 set copies the live time into a snapshot on that edge, and bit 6 always reads back 0. While control bit 7 is 1, reads of 0x00 to 0x06 return the snapshot. Otherwise they return the live time.
- R7: Status bit 6 (alarm) sets on a counted tick whose new second, minute, hour, day, month and year all equal alarm bytes 0x07 to 0x0C, in that order. A tick that produces any other time does not set it.
- R8: Status bits 2, 3, 4 and 5 set on a counted tick, a minute carry, an hour carry and a day carry respectively.
- R9: Writing 1 to status bits 2 to 7 (offset 0x0E) clears those flags. Writing 0 leaves them unchanged, bits 0 and 1 ignore writes, and the power-up flag (bit 7) is never set again after reset.
- R10: `irq` = (alarm flag AND enable bit 3) OR (selected event flag AND enable bit 2). Enable bits 1:0 select the event: 0 second, 1 minute, 2 hour, 3 day (offset 0x0F).
- R11: Control bits 1 to 5 are stored and read back but have no effect on counting. Enable bits 7:4 read as 0, and offsets above 0x0F read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, taken on the same edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The test table targets every day-wrap case: a month of 30 days, a month of 31 days, February 28 and 29 in a leap year, February 28 in a common year, and the wrap from December 31, year 99. A design that got the month-length or leap-year decode wrong would show a day such as 0x31 or 0x29, or a month that failed to advance. The directed tests check several timing points:
- A snapshot taken before further ticks still returns the old seconds, while the live time has moved on.
- Writes to the time bytes are ignored while running.
- The alarm flag sets exactly on the matching tick and stays clear one tick later.
- Write-one-clear leaves the neighbouring flags intact.
- The event select changes `irq` with no tick in between.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FW     = 8;  // bits per BCD field
  localparam int NFIELD = 7;  // sec, min, hour, day, month, year, weekday
  localparam int NALM   = 6;  // fields compared by the alarm
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DAY = 3, F_MON = 4, F_YEAR = 5, F_WDAY = 6;

  typedef logic [FW-1:0] bcd_t;
  typedef logic [NFIELD-1:0][FW-1:0] rtc_time_t;
  typedef logic [NALM-1:0][FW-1:0] alm_time_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(bcd_t y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return b[1:0] == 2'd0;
  endfunction

  function automatic bcd_t month_last(bcd_t m, bcd_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      ld_en,
  input  logic [2:0] ld_idx,
  input  bcd_t      ld_val,
  output rtc_time_t cur,
  output alm_time_t nxt_cal,
  output logic      ev_min,
  output logic      ev_hour,
  output logic      ev_day
);
  localparam rtc_time_t RESET_T = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  rtc_time_t nxt;
  logic c_min, c_hour, c_day, c_mon, c_yr;

  // Ripple of carries from seconds up to the year
  always_comb begin
    nxt = cur;
    c_min = 1'b0; c_hour = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    if (cur[F_SEC] >= 8'h59) begin nxt[F_SEC] = '0; c_min = 1'b1; end
    else nxt[F_SEC] = bcd_inc(cur[F_SEC]);
    if (c_min) begin
      if (cur[F_MIN] >= 8'h59) begin nxt[F_MIN] = '0; c_hour = 1'b1; end
      else nxt[F_MIN] = bcd_inc(cur[F_MIN]);
    end
    if (c_hour) begin
      if (cur[F_HOUR] >= 8'h23) begin nxt[F_HOUR] = '0; c_day = 1'b1; end
      else nxt[F_HOUR] = bcd_inc(cur[F_HOUR]);
    end
    if (c_day) begin
      nxt[F_WDAY] = (cur[F_WDAY] >= 8'h06) ? '0 : bcd_inc(cur[F_WDAY]);
      if (cur[F_DAY] >= month_last(cur[F_MON], cur[F_YEAR])) begin nxt[F_DAY] = 8'h01; c_mon = 1'b1; end
      else nxt[F_DAY] = bcd_inc(cur[F_DAY]);
    end
    if (c_mon) begin
      if (cur[F_MON] >= 8'h12) begin nxt[F_MON] = 8'h01; c_yr = 1'b1; end
      else nxt[F_MON] = bcd_inc(cur[F_MON]);
    end
    if (c_yr) nxt[F_YEAR] = (cur[F_YEAR] >= 8'h99) ? '0 : bcd_inc(cur[F_YEAR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur <= RESET_T;
    else if (ld_en) cur[ld_idx] <= ld_val;
    else if (adv)   cur <= nxt;
  end

  assign nxt_cal = nxt[NALM-1:0];
  assign ev_min  = adv & c_min;
  assign ev_hour = adv & c_hour;
  assign ev_day  = adv & c_day;

  // R4: with no advance and no load the time must not move
  a_r4_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld_en) |=> $stable(cur));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match import rtc_pkg::*; (
  input  alm_time_t probe,
  input  alm_time_t alarm,
  output logic      hit
);
  logic [NALM-1:0] eq;
  for (genvar i = 0; i < NALM; i++) begin : g_cmp
    assign eq[i] = (probe[i] == alarm[i]);
  end
  assign hit = &eq;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc import rtc_pkg::*; #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [FW-1:0] bus_wdata,
  output logic [FW-1:0] bus_rdata,
  output logic          irq
);
  localparam int A_ALM0 = NFIELD;
  localparam int A_CTRL = A_ALM0 + NALM;
  localparam int A_STAT = A_CTRL + 1;
  localparam int A_IE   = A_CTRL + 2;
  localparam int C_RUN = 0, C_SNAP = 6, C_RDSNAP = 7;

  logic [FW-1:0] ctrl_q;
  logic          run_q, alm_q, pwr_q;
  logic [3:0]    evt_q;      // second, minute, hour, day
  logic [3:0]    ie_q;
  alm_time_t     alm_regs;
  rtc_time_t     snap_q, live;
  alm_time_t     nxt_cal;
  logic          ev_min, ev_hour, ev_day, match, alarm_hit, adv;
  logic          in_time, in_alm, wr_ctrl;
  logic [2:0]    alm_idx;
  logic [FW-1:0] st_clr;

  assign adv       = sec_tick & ctrl_q[C_RUN];
  assign in_time   = bus_addr < AW'(NFIELD);
  assign in_alm    = !in_time && (bus_addr < AW'(A_CTRL));
  assign alm_idx   = 3'(bus_addr - AW'(A_ALM0));
  assign wr_ctrl   = bus_wr && (bus_addr == AW'(A_CTRL));
  assign st_clr    = (bus_wr && bus_addr == AW'(A_STAT)) ? bus_wdata : '0;
  assign alarm_hit = adv & match;

  rtc_calendar u_cal (
    .clk, .rst_n, .adv,
    .ld_en  (bus_wr && in_time && !ctrl_q[C_RUN]),
    .ld_idx (bus_addr[2:0]),
    .ld_val (bus_wdata),
    .cur    (live),
    .nxt_cal,
    .ev_min, .ev_hour, .ev_day
  );

  rtc_alarm_match u_alm (.probe(nxt_cal), .alarm(alm_regs), .hit(match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; run_q <= 1'b0; alm_q <= 1'b0; pwr_q <= 1'b1;
      evt_q <= '0; ie_q <= '0; alm_regs <= '0; snap_q <= '0;
    end else begin
      if (sec_tick) run_q <= ctrl_q[C_RUN];
      if (wr_ctrl) ctrl_q <= bus_wdata & ~(FW'(1) << C_SNAP);
      if (wr_ctrl && bus_wdata[C_SNAP]) snap_q <= live;
      if (bus_wr && bus_addr == AW'(A_IE)) ie_q <= bus_wdata[3:0];
      if (bus_wr && in_alm) alm_regs[alm_idx] <= bus_wdata;
      evt_q <= (evt_q & ~st_clr[5:2]) | {ev_day, ev_hour, ev_min, adv};
      alm_q <= (alm_q & ~st_clr[6]) | alarm_hit;
      pwr_q <= pwr_q & ~st_clr[7];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_time)                          bus_rdata = ctrl_q[C_RDSNAP] ? snap_q[bus_addr[2:0]] : live[bus_addr[2:0]];
    else if (in_alm)                      bus_rdata = alm_regs[alm_idx];
    else if (bus_addr == AW'(A_CTRL))     bus_rdata = ctrl_q;
    else if (bus_addr == AW'(A_STAT))     bus_rdata = {pwr_q, alm_q, evt_q, run_q, 1'b0};
    else if (bus_addr == AW'(A_IE))       bus_rdata = {4'b0, ie_q};
  end

  assign irq = (alm_q & ie_q[3]) | (evt_q[ie_q[1:0]] & ie_q[2]);

  a_r5_run_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (run_q == $past(ctrl_q[C_RUN])));
  a_r6_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[C_SNAP]) |=> (snap_q == $past(live)));
  a_r7_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> alm_q);
  a_r9_pwr_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> !pwr_q);
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q[2] | ie_q[3]));
endmodule

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
  logic       clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, d;
  logic       irq;
  logic [47:0] got;
  int checks = 0, errors = 0;

  localparam logic [4:0] CTRL = 5'h0D, STAT = 5'h0E, IE = 5'h0F;
  // {sec,min,hour,day,mon,year loaded} {expected after one tick}
  localparam logic [95:0] VEC [0:9] = '{
    96'h000000050624_010000050624,  // R2 plain second
    96'h591210050624_001310050624,  // R2 minute carry
    96'h595923150724_000000160724,  // R2 hour wrap, day advance
    96'h595923300424_000000010524,  // R3 30-day month
    96'h595923280224_000000290224,  // R3 leap Feb 28
    96'h595923290224_000000010324,  // R3 leap Feb 29
    96'h595923280223_000000010323,  // R3 common Feb 28
    96'h595923311299_000000010100,  // R3 year wrap
    96'h595923310125_000000010225,  // R3 31-day month
    96'h595923300925_000000011025   // R3 BCD month 09 -> 10
  };

  bcd_rtc u0 (.clk, .rst_n, .sec_tick, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata, .irq);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk); #1 chk(req, 64'(irq), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(STAT, d); chk("R1 status", 64'(d), 64'h80);
    rd(CTRL, d); chk("R1 ctrl", 64'(d), 64'h00);
    rd(5'h00, d); chk("R1 sec", 64'(d), 64'h00);
    rd(5'h03, d); chk("R1 day", 64'(d), 64'h01);
    rd(5'h04, d); chk("R1 month", 64'(d), 64'h01);
    rd(IE, d); chk("R1 ie", 64'(d), 64'h00);
    irq_chk("R1 irq", 1'b0);
    // R5 run bit follows ctrl only at a tick
    wr(CTRL, 8'h01);
    rd(STAT, d); chk("R5 before tick", 64'(d), 64'h80);
    tick();
    rd(STAT, d); chk("R5 R8 after tick", 64'(d), 64'h86);
    // R4 writes ignored while running, loaded while stopped
    wr(5'h00, 8'h33);
    rd(5'h00, d); chk("R4 write while running", 64'(d), 64'h01);
    wr(CTRL, 8'h00); tick();
    rd(5'h00, d); chk("R4 stopped tick", 64'(d), 64'h01);
    wr(5'h00, 8'h33);
    rd(5'h00, d); chk("R4 load while stopped", 64'(d), 64'h33);
    // R2/R3 table
    foreach (VEC[i]) begin
      wr(CTRL, 8'h00);
      for (int k = 0; k < 6; k++) wr(5'(k), VEC[i][48 + 8*(5-k) +: 8]);
      wr(CTRL, 8'h01);
      tick();
      for (int k = 0; k < 6; k++) begin
        rd(5'(k), d); got[8*(5-k) +: 8] = d;
      end
      chk($sformatf("R2 R3 vector %0d", i), 64'(got), 64'(VEC[i][47:0]));
    end
    wr(CTRL, 8'h00);
    // R6 snapshot
    wr(5'h00, 8'h10);
    wr(CTRL, 8'hC1); tick(); tick();
    rd(5'h00, d); chk("R6 snapshot sec", 64'(d), 64'h10);
    rd(CTRL, d); chk("R6 bit6 reads 0", 64'(d), 64'h81);
    wr(CTRL, 8'h01);
    rd(5'h00, d); chk("R6 live sec", 64'(d), 64'h12);
    // R8/R9 event flags and write-one-clear
    wr(CTRL, 8'h00);
    wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h10);
    wr(STAT, 8'hFC); wr(CTRL, 8'h01); tick();
    rd(STAT, d); chk("R8 R9 sec min hour flags", 64'(d), 64'h1E);
    wr(STAT, 8'h04);
    rd(STAT, d); chk("R9 clear sec flag only", 64'(d), 64'h1A);
    wr(STAT, 8'h03);
    rd(STAT, d); chk("R9 low bits ignore writes", 64'(d), 64'h1A);
    // R10 event select
    wr(IE, 8'h05); irq_chk("R10 minute select", 1'b1);
    wr(IE, 8'h06); irq_chk("R10 hour select", 1'b1);
    wr(IE, 8'h07); irq_chk("R10 day select", 1'b0);
    wr(IE, 8'h04); irq_chk("R10 second select", 1'b0);
    wr(IE, 8'h00);
    // R7 alarm
    wr(CTRL, 8'h00);
    wr(5'h00, 8'h58); wr(5'h01, 8'h30); wr(5'h02, 8'h08);
    wr(5'h03, 8'h14); wr(5'h04, 8'h03); wr(5'h05, 8'h25);
    wr(5'h07, 8'h59); wr(5'h08, 8'h30); wr(5'h09, 8'h08);
    wr(5'h0A, 8'h14); wr(5'h0B, 8'h03); wr(5'h0C, 8'h25);
    wr(STAT, 8'hFC); wr(IE, 8'h08); wr(CTRL, 8'h01);
    irq_chk("R10 alarm not yet", 1'b0);
    tick();
    rd(STAT, d); chk("R7 alarm flag set", 64'(d), 64'h46);
    irq_chk("R10 alarm irq", 1'b1);
    wr(STAT, 8'h40); irq_chk("R9 alarm cleared", 1'b0);
    tick();
    rd(STAT, d); chk("R7 no match next tick", 64'(d & 8'h40), 64'h00);
    // R3 weekday wrap, R8 day flag
    wr(CTRL, 8'h00);
    wr(5'h06, 8'h06); wr(5'h02, 8'h23); wr(5'h01, 8'h59); wr(5'h00, 8'h59);
    wr(STAT, 8'hFC); wr(CTRL, 8'h01); tick();
    rd(5'h06, d); chk("R3 weekday wrap", 64'(d), 64'h00);
    rd(STAT, d); chk("R8 day flag", 64'(d & 8'h20), 64'h20);
    // R11 inert bits and unmapped reads
    wr(CTRL, 8'h3E);
    rd(CTRL, d); chk("R11 ctrl readback", 64'(d), 64'h3E);
    rd(5'h00, d); got[7:0] = d; tick();
    rd(5'h00, d); chk("R11 inert bits do not run", 64'(d), 64'(got[7:0]));
    wr(IE, 8'hFF);
    rd(IE, d); chk("R11 ie upper bits", 64'(d), 64'h0F);
    rd(5'h15, d); chk("R11 unmapped", 64'(d), 64'h00);
    rd(5'h10, d); chk("R11 unmapped 0x10", 64'(d), 64'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule